// File: doc/BRIEF.md
# Shadowed Page Commit Controller

This block holds a 256-byte store made of a nonvolatile array, modelled as registers and grouped into 8-byte pages, with a window of volatile shadow registers in front of part of it. A bus front end hands it single byte writes. Writes outside the shadow window are staged in a one-page buffer. A write inside the window updates the volatile copy at once and, unless shadow-only mode is on, is staged as well. When the front end sees the end of a transaction it pulses a commit request. The staged page is then programmed into the array as a whole page during a programmable busy interval, and that page's wear counter is incremented.

While the block is busy it takes no writes and no commit requests, in the same way that a device stops answering its address while it programs. A power-on reset gives the array its initial contents. A normal reset reloads the shadow registers from the array and leaves the array and the wear counters untouched.

Top module: `shadow_page_commit`

## Requirements
- R1: While `por_n` is low, array byte `a` becomes `a XOR POR_XOR`, with `POR_XOR` defaulting to 8'h5A. Every wear counter becomes 0 and `busy` is 0. The shadow registers take the same values as the array bytes behind them.
- R2: While `rst_n` is low and `por_n` is high, each shadow register reloads from its array byte, staged bytes are dropped and `busy` clears. The array contents and the wear counters are kept.
- R3: `rd_data` is combinational. It returns the shadow register for addresses in pages `SH_PAGE_LO`..`SH_PAGE_HI` (29..30 by default, so 0xE8..0xF7) and the array byte for every other address.
- R4: A commit programs only the written bytes of the staged page with their new values. The other bytes of that page keep their previous array values. A staged write is invisible at `rd_data` outside the shadow window until its program completes.
- R5: An accepted commit raises `busy` in the next cycle. `busy` then stays high for exactly `TW_CYCLES` cycles. The array update and the wear increment become visible in the cycle in which `busy` falls.
- R6: Each page program adds exactly 1 to the wear counter of that page (`wear_cnt` for `wear_sel` = address bits 7:3). The counter saturates at its all-ones value.
- R7: A commit request with no byte staged starts no program. It leaves `busy` low and the wear counters unchanged.
- R8: While `busy` is high, `wr_en` and `commit_req` are ignored. Writes offered during that time are neither staged nor shown in the shadow registers.
- R9: With `shadow_en` at 1, a write into the shadow window changes only the shadow register. A later commit then raises no `busy` and counts no wear.
- R10: With `shadow_en` at 0, a write into the shadow window appears on `rd_data` at once and is also staged, so the next commit programs it and counts wear.
- R11: A write to a page other than the one holding staged bytes drops the earlier staged bytes and starts staging the new page.
- R12: A write in the same cycle as a commit request is included in that commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, gives the array its initial contents |
| rst_n | input | 1 | Normal reset, active low, reloads the shadow registers |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | ADDR_W | Byte write address |
| wr_data | input | 8 | Byte write data |
| shadow_en | input | 1 | Shadow-only mode for writes inside the window |
| commit_req | input | 1 | End of transaction, program the staged page |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data (shadow register or array byte) |
| wear_sel | input | ADDR_W-PAGE_W | Page whose wear count is shown |
| wear_cnt | output | WEAR_W | Program count of the selected page |
| busy | output | 1 | Page program in progress |

## Verification
A corrupted staging mask or pending page does not show at once. It shows one program interval later, when `rd_data` for a neighbouring byte of the page differs, or when the wear count lands on the wrong page. A bad shadow register differs on `rd_data` in the cycle after the write. A timer fault shows as a `busy` run of the wrong length, and the bench sees it at the falling edge. A wrongly cleared staging buffer shows up as a commit that raises no `busy`.

// File: rtl/spc_pkg.sv
package spc_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/spc_stager.sv
module spc_stager
    import spc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 3,
    localparam int PB = 1 << PAGE_W,
    localparam int PIDX_W = ADDR_W - PAGE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  stage_wr,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  byte_t                 wr_data,
    input  logic                  commit_req,
    input  logic                  busy,
    output logic                  go,
    output logic [PIDX_W-1:0]     go_page,
    output logic [PB-1:0]         go_mask,
    output logic [PB-1:0][BYTE_W-1:0] go_data
);
    typedef struct packed {
        logic [PIDX_W-1:0]         page;
        logic [PB-1:0]             mask;
        logic [PB-1:0][BYTE_W-1:0] data;
    } stage_t;

    stage_t s_d, s_q;
    logic [PIDX_W-1:0] w_page;
    logic [PAGE_W-1:0] w_off;

    assign w_page = wr_addr[ADDR_W-1:PAGE_W];
    assign w_off  = wr_addr[PAGE_W-1:0];

    always_comb begin
        s_d = s_q;
        if (stage_wr && !busy) begin
            if (s_q.page != w_page) begin
                s_d.mask = '0;
            end
            s_d.page        = w_page;
            s_d.mask[w_off] = 1'b1;
            s_d.data[w_off] = wr_data;
        end
        go      = commit_req && !busy && (s_d.mask != '0);
        go_page = s_d.page;
        go_mask = s_d.mask;
        go_data = s_d.data;
        if (go) begin
            s_d.mask = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/spc_timer.sv
module spc_timer #(
    parameter int TW_CYCLES = 20,
    localparam int CNT_W = (TW_CYCLES > 1) ? $clog2(TW_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic busy,
    output logic done
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d  = t_q;
        done = t_q.busy && (t_q.cnt == '0);
        if (done) begin
            t_d.busy = 1'b0;
        end else if (t_q.busy) begin
            t_d.cnt = t_q.cnt - 1'b1;
        end
        if (go) begin
            t_d.busy = 1'b1;
            t_d.cnt  = CNT_W'(TW_CYCLES - 1);
        end
    end

    assign busy = t_q.busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end
endmodule

// File: rtl/shadow_page_commit.sv
module shadow_page_commit
    import spc_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter int          PAGE_W     = 3,
    parameter int          SH_PAGE_LO = 29,
    parameter int          SH_PAGE_HI = 30,
    parameter int          TW_CYCLES  = 20,
    parameter int          WEAR_W     = 16,
    parameter logic [7:0]  POR_XOR    = 8'h5A,
    localparam int DEPTH    = 1 << ADDR_W,
    localparam int PB       = 1 << PAGE_W,
    localparam int PIDX_W   = ADDR_W - PAGE_W,
    localparam int NPAGES   = 1 << PIDX_W,
    localparam int SH_BASE  = SH_PAGE_LO * PB,
    localparam int SH_BYTES = (SH_PAGE_HI - SH_PAGE_LO + 1) * PB,
    localparam int SH_IW    = (SH_BYTES > 1) ? $clog2(SH_BYTES) : 1
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              shadow_en,
    input  logic              commit_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic [PIDX_W-1:0] wear_sel,
    output logic [WEAR_W-1:0] wear_cnt,
    output logic              busy
);
    typedef struct packed {
        logic [DEPTH-1:0][BYTE_W-1:0]    nv;
        logic [SH_BYTES-1:0][BYTE_W-1:0] sh;
        logic [NPAGES-1:0][WEAR_W-1:0]   wear;
        logic [PIDX_W-1:0]               pend_page;
        logic [PB-1:0]                   pend_mask;
        logic [PB-1:0][BYTE_W-1:0]       pend_data;
    } state_t;

    state_t st_d, st_q, por_v, rst_v;

    logic                      core_rst_n;
    logic                      wr_hit, rd_hit, stage_wr, go, done;
    logic [ADDR_W-1:0]         wr_off, rd_off;
    logic [PIDX_W-1:0]         go_page;
    logic [PB-1:0]             go_mask;
    logic [PB-1:0][BYTE_W-1:0] go_data;

    assign core_rst_n = por_n && rst_n;

    function automatic logic in_window(input logic [ADDR_W-1:0] a);
        logic [PIDX_W-1:0] p;
        p = a[ADDR_W-1:PAGE_W];
        return (p >= PIDX_W'(SH_PAGE_LO)) && (p <= PIDX_W'(SH_PAGE_HI));
    endfunction

    assign wr_hit   = in_window(wr_addr);
    assign rd_hit   = in_window(rd_addr);
    assign wr_off   = wr_addr - ADDR_W'(SH_BASE);
    assign rd_off   = rd_addr - ADDR_W'(SH_BASE);
    assign stage_wr = wr_en && !(wr_hit && shadow_en);

    spc_stager #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_stager (
        .clk        (clk),
        .rst_n      (core_rst_n),
        .stage_wr   (stage_wr),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .commit_req (commit_req),
        .busy       (busy),
        .go         (go),
        .go_page    (go_page),
        .go_mask    (go_mask),
        .go_data    (go_data)
    );

    spc_timer #(.TW_CYCLES(TW_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (core_rst_n),
        .go    (go),
        .busy  (busy),
        .done  (done)
    );

    // Initial array contents and the reload image used by the normal reset
    always_comb begin
        por_v = '0;
        for (int a = 0; a < DEPTH; a++) begin
            por_v.nv[a] = BYTE_W'(a) ^ POR_XOR;
        end
        for (int j = 0; j < SH_BYTES; j++) begin
            por_v.sh[j] = BYTE_W'(SH_BASE + j) ^ POR_XOR;
        end
        rst_v           = st_q;
        rst_v.pend_mask = '0;
        for (int j = 0; j < SH_BYTES; j++) begin
            rst_v.sh[j] = st_q.nv[SH_BASE + j];
        end
    end

    always_comb begin
        st_d = st_q;
        if (wr_en && !busy && wr_hit) begin
            st_d.sh[wr_off[SH_IW-1:0]] = wr_data;
        end
        if (go) begin
            st_d.pend_page = go_page;
            st_d.pend_mask = go_mask;
            st_d.pend_data = go_data;
        end
        if (done) begin
            for (int i = 0; i < PB; i++) begin
                if (st_q.pend_mask[i]) begin
                    st_d.nv[{st_q.pend_page, PAGE_W'(i)}] = st_q.pend_data[i];
                end
            end
            if (st_q.wear[st_q.pend_page] != '1) begin
                st_d.wear[st_q.pend_page] = st_q.wear[st_q.pend_page] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            st_q <= por_v;
        end else if (!rst_n) begin
            st_q <= rst_v;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data  = rd_hit ? st_q.sh[rd_off[SH_IW-1:0]] : st_q.nv[rd_addr];
    assign wear_cnt = st_q.wear[wear_sel];
endmodule

// File: rtl/spc_checker.sv
module spc_checker #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 3,
    parameter int TW     = 20,
    parameter int WEAR_W = 16
) (
    input logic                     clk,
    input logic                     por_n,
    input logic                     rst_n,
    input logic                     commit_req,
    input logic [ADDR_W-1:0]        rd_addr,
    input logic [7:0]               rd_data,
    input logic [ADDR_W-PAGE_W-1:0] wear_sel,
    input logic [WEAR_W-1:0]        wear_cnt,
    input logic                     busy
);
    int run_q;

    always_ff @(posedge clk) begin
        if (!por_n || !rst_n) begin
            run_q <= 0;
        end else if (busy) begin
            run_q <= run_q + 1;
        end else begin
            run_q <= 0;
        end
    end

    // R5: a busy run lasts exactly TW cycles
    a_r5_busy_exact: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        $fell(busy) |-> run_q == TW);
    a_r5_busy_bound: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        busy |-> run_q < TW);

    // R7: busy only follows a commit request
    a_r7_busy_cause: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        $rose(busy) |-> $past(commit_req));

    // R6: wear count moves only when a program ends, and then by at most one
    a_r6_wear_hold: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        ($stable(wear_sel) && !$fell(busy)) |-> $stable(wear_cnt));
    a_r6_wear_step: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        ($stable(wear_sel) && $fell(busy)) |->
            (wear_cnt == $past(wear_cnt) || wear_cnt == $past(wear_cnt) + 1'b1));

    // R8: nothing readable changes inside a busy interval
    a_r8_frozen: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (busy && $past(busy) && $stable(rd_addr)) |-> $stable(rd_data));
endmodule

bind shadow_page_commit spc_checker #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W),
    .TW     (TW_CYCLES),
    .WEAR_W (WEAR_W)
) u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .rst_n      (rst_n),
    .commit_req (commit_req),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .wear_sel   (wear_sel),
    .wear_cnt   (wear_cnt),
    .busy       (busy)
);

// File: tb/shadow_page_commit_bench.sv
`timescale 1ns/1ps
module shadow_page_commit_bench;
    localparam int TW   = 5;
    localparam int WW   = 3;
    localparam int WMAX = (1 << WW) - 1;

    logic       clk = 1'b0;
    logic       por_n = 1'b0, rst_n = 1'b0;
    logic       wr_en = 1'b0, shadow_en = 1'b0, commit_req = 1'b0;
    logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
    logic [4:0] wear_sel = '0;
    logic [7:0] rd_data;
    logic [WW-1:0] wear_cnt;
    logic       busy;

    int checks = 0, errors = 0;
    string cur_req = "R1";
    bit finished = 0;

    always #2 clk = ~clk;

    shadow_page_commit #(.TW_CYCLES(TW), .WEAR_W(WW)) u_shadow_page_commit (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .shadow_en(shadow_en), .commit_req(commit_req),
        .rd_addr(rd_addr), .rd_data(rd_data), .wear_sel(wear_sel),
        .wear_cnt(wear_cnt), .busy(busy)
    );

    // Behavioural reference model
    int m_nv[256];
    int m_vol[256];
    int m_wear[32];
    int m_spage = 0;
    int m_sdata[8];
    bit m_smask[8];
    int m_ppage = 0;
    int m_pdata[8];
    bit m_pmask[8];
    int m_left = 0;

    function automatic bit win(int a);
        return (a >= 'hE8) && (a <= 'hF7);
    endfunction

    function automatic int m_read(int a);
        return win(a) ? m_vol[a] : m_nv[a];
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!por_n) begin
            for (int a = 0; a < 256; a++) begin
                m_nv[a] = a ^ 'h5A;
                m_vol[a] = a ^ 'h5A;
            end
            for (int p = 0; p < 32; p++) m_wear[p] = 0;
            for (int i = 0; i < 8; i++) m_smask[i] = 0;
            m_spage = 0;
            m_left = 0;
        end else if (!rst_n) begin
            for (int a = 0; a < 256; a++) m_vol[a] = m_nv[a];
            for (int i = 0; i < 8; i++) m_smask[i] = 0;
            m_left = 0;
        end else if (m_left > 0) begin
            m_left--;
            if (m_left == 0) begin
                for (int i = 0; i < 8; i++)
                    if (m_pmask[i]) m_nv[m_ppage*8 + i] = m_pdata[i];
                if (m_wear[m_ppage] < WMAX) m_wear[m_ppage]++;
            end
        end else begin
            bit any;
            if (wr_en) begin
                if (win(wr_addr)) m_vol[wr_addr] = wr_data;
                if (!(win(wr_addr) && shadow_en)) begin
                    if (m_spage != wr_addr / 8)
                        for (int i = 0; i < 8; i++) m_smask[i] = 0;
                    m_spage = wr_addr / 8;
                    m_smask[wr_addr % 8] = 1;
                    m_sdata[wr_addr % 8] = wr_data;
                end
            end
            any = 0;
            for (int i = 0; i < 8; i++) any |= m_smask[i];
            if (commit_req && any) begin
                m_ppage = m_spage;
                for (int i = 0; i < 8; i++) begin
                    m_pmask[i] = m_smask[i];
                    m_pdata[i] = m_sdata[i];
                    m_smask[i] = 0;
                end
                m_left = TW;
            end
        end
        #1;
        if (por_n && rst_n) begin
            chk({cur_req, " rd_data"}, rd_data, m_read(rd_addr));
            chk({cur_req, " busy"}, busy, m_left > 0);
            chk({cur_req, " wear"}, wear_cnt, m_wear[wear_sel]);
        end
    end

    task automatic drive(bit we, int a, int d, bit see, bit cm);
        @(negedge clk);
        wr_en = we; wr_addr = 8'(a); wr_data = 8'(d); shadow_en = see; commit_req = cm;
    endtask

    task automatic idle_until_free();
        @(negedge clk);
        wr_en = 0; commit_req = 0;
        while (busy) @(negedge clk);
    endtask

    task automatic peek(string req, int a, int exp);
        @(negedge clk);
        wr_en = 0; commit_req = 0; rd_addr = 8'(a);
        #0.5;
        chk(req, rd_data, exp);
    endtask

    task automatic peek_wear(string req, int p, int exp);
        @(negedge clk);
        wr_en = 0; commit_req = 0; wear_sel = 5'(p);
        #0.5;
        chk(req, wear_cnt, exp);
    endtask

    initial begin
        int run;
        repeat (3) @(negedge clk);
        por_n = 1;
        repeat (2) @(negedge clk);
        rst_n = 1;

        cur_req = "R1";
        peek("R1 por byte 00", 'h00, 'h5A);
        peek("R1 por shadow F3", 'hF3, 'hA9);
        chk("R1 busy idle", busy, 0);
        peek_wear("R1 wear zero", 2, 0);

        cur_req = "R4";
        drive(1, 'h11, 'hAA, 0, 0);
        drive(1, 'h13, 'hBB, 0, 0);
        peek("R4 staged not visible", 'h11, 'h4B);
        cur_req = "R5";
        drive(0, 0, 0, 0, 1);
        @(negedge clk);
        commit_req = 0;
        run = 0;
        while (busy) begin run++; @(negedge clk); end
        chk("R5 busy length", run, TW);
        peek("R4 written byte 11", 'h11, 'hAA);
        peek("R4 untouched byte 12", 'h12, 'h48);
        peek("R4 written byte 13", 'h13, 'hBB);
        peek_wear("R6 one program", 2, 1);

        cur_req = "R8";
        drive(1, 'h15, 'h01, 0, 1);
        drive(1, 'h20, 'h77, 0, 1);
        drive(0, 0, 0, 0, 1);
        idle_until_free();
        peek("R8 write during busy dropped", 'h20, 'h7A);
        peek_wear("R8 commit during busy ignored", 4, 0);
        peek_wear("R8 single program", 2, 2);

        cur_req = "R7";
        drive(0, 0, 0, 0, 1);
        @(negedge clk);
        commit_req = 0;
        chk("R7 empty commit no busy", busy, 0);
        peek_wear("R7 wear kept", 2, 2);

        cur_req = "R9";
        drive(1, 'hF2, 'h33, 1, 0);
        peek("R9 shadow updated", 'hF2, 'h33);
        drive(0, 0, 0, 0, 1);
        @(negedge clk);
        commit_req = 0;
        chk("R9 no busy", busy, 0);
        peek_wear("R9 no wear", 30, 0);

        cur_req = "R10";
        drive(1, 'hE9, 'h44, 0, 0);
        peek("R10 shadow immediate", 'hE9, 'h44);
        drive(0, 0, 0, 0, 1);
        idle_until_free();
        peek_wear("R10 wear counted", 29, 1);

        cur_req = "R2";
        @(negedge clk);
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        peek("R2 shadow reloaded", 'hF2, 'hA8);
        peek("R2 programmed shadow kept", 'hE9, 'h44);
        peek("R3 array byte read", 'h13, 'hBB);
        peek_wear("R2 wear kept", 29, 1);

        cur_req = "R11";
        drive(1, 'h40, 'h01, 0, 0);
        drive(1, 'h48, 'h02, 0, 0);
        drive(0, 0, 0, 0, 1);
        idle_until_free();
        peek("R11 dropped byte", 'h40, 'h1A);
        peek("R11 new page byte", 'h48, 'h02);
        peek_wear("R11 old page no wear", 8, 0);
        peek_wear("R11 new page wear", 9, 1);

        cur_req = "R12";
        drive(1, 'h50, 'h66, 0, 1);
        @(negedge clk);
        commit_req = 0; wr_en = 0;
        chk("R12 busy after same-cycle commit", busy, 1);
        idle_until_free();
        peek("R12 byte programmed", 'h50, 'h66);

        cur_req = "R6";
        for (int k = 0; k < WMAX + 2; k++) begin
            drive(1, 'h60 + k % 8, k, 0, 1);
            idle_until_free();
        end
        peek_wear("R6 saturated", 12, WMAX);

        repeat (2) @(negedge clk);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule